// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-level control and status registers of a 32-bit RISC-V core. The decode stage gives it one CSR access per cycle: a 12-bit address, an operation kind, and a source. The source is either a register value or a 5-bit immediate. Flags mark a zero destination or a zero source register. In the same cycle the block returns the register's previous contents for write-back, and it commits the new value at the next clock edge.

The block also takes the core from normal flow into a trap and back out again. A trap request carries a cause code and the current PC. An illegal CSR access raises a trap by itself. Both kinds redirect the next PC to the trap vector in the same cycle and save the PC, the cause and the interrupt-enable state. A return strobe sends the PC back to the saved exception address and restores the interrupt-enable state. A free-running cycle counter and a retired-instruction counter are both 64 bits wide and are read and written in two 32-bit halves.

Top module: `mcsr_trap_unit`

## Requirements
- R1: With `op_valid` high, `rdata` returns the addressed register's previous value in the same cycle. `op_kind` 01 writes the source, 10 writes old OR source, 11 writes old AND NOT source, and 00 only reads. The new value is visible from the next cycle on.
- R2: With `op_imm` high the source is `zimm`, zero-extended to 32 bits, and `rs1_val` is ignored. With `op_imm` low the source is `rs1_val`.
- R3: A set or clear whose source is zero (`rs1_zero` in register form, `zimm` = 0 in immediate form) writes nothing. It is therefore legal on read-only addresses.
- R4: A write (kind 01) with `rd_zero` high drives `rdata` to 0 but still writes the register.
- R5: After reset the status register at 0x300 reads 0x00001800: previous-privilege bits [12:11] are always 11, and the enable bits [3] and [7] are 0. The ISA register at 0x301 reads 0x40001100. Addresses 0xF11, 0xF12, 0xF13 and 0xF14 read 0, 0, 1 and 0.
- R6: An access to an unimplemented address, or a write attempt to an address whose bits [11:10] are 11, raises `illegal`. It takes a trap in the same cycle: `redirect` goes high with the trap vector as target, the saved cause becomes 2, the trap value (0x343) becomes 0, and no CSR is written.
- R7: On `trap_req` the unit raises `redirect` with `redirect_pc` = trap vector (0x305) in the same cycle. It stores `cur_pc` with bits [1:0] cleared into 0x341, the zero-extended `trap_cause` into 0x342, and 0 into 0x343.
- R8: On any trap entry, status bit [7] takes the value of status bit [3], and bit [3] is cleared.
- R9: On `mret_req` the unit raises `redirect` with `redirect_pc` = the saved exception address. Status bit [3] takes the value of bit [7], and bit [7] becomes 1.
- R10: The cycle counter (low half at 0xB00, high half at 0xB80) increments on every clock. A carry from the low half propagates into the high half.
- R11: The retired-instruction counter (low half at 0xB02, high half at 0xB82) increments once per clock with `retire` high.
- R12: A CSR write to either half of a counter replaces that cycle's increment.
- R13: Bits [1:0] of the exception address (0x341) and of the trap vector (0x305) always read 0. Only bits 3, 7 and 11 of the interrupt-enable register (0x304) are writable. The pending register (0x344) reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | 32 | PC of the instruction in this stage |
| op_valid | input | 1 | A CSR access is presented this cycle |
| op_kind | input | 2 | 00 read, 01 write, 10 set, 11 clear |
| op_imm | input | 1 | Immediate form: source is zimm |
| csr_addr | input | 12 | CSR address |
| rs1_val | input | 32 | Register-form source |
| zimm | input | 5 | Immediate-form source |
| rd_zero | input | 1 | Destination register is x0 |
| rs1_zero | input | 1 | Source register is x0 |
| trap_req | input | 1 | Environment call or breakpoint trap request |
| trap_cause | input | 5 | Cause code for trap_req |
| mret_req | input | 1 | Return-from-trap strobe |
| retire | input | 1 | One instruction retired this cycle |
| rdata | output | 32 | Previous CSR value for write-back |
| illegal | output | 1 | Current CSR access is illegal |
| redirect | output | 1 | Next PC must be taken from redirect_pc |
| redirect_pc | output | 32 | Trap vector or return address |

## Verification
The assertions assume that `trap_req`, `op_valid` and `mret_req` are at most one-hot in any cycle. The core issues one instruction at a time, and the bench drives each request from its own task so that none overlaps another. The checks on the trap path rely on the trap vector held in the unit. The bench therefore keeps its own copy of every writable register and updates it from the same accesses it drives. Random accesses go only to fully implemented writable addresses. The illegal and read-only cases are driven directly, so the random stream never raises an unplanned trap.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
   localparam int ZIMM_W = 5;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   localparam logic [11:0] ADR_STATUS  = 12'h300;
   localparam logic [11:0] ADR_ISA     = 12'h301;
   localparam logic [11:0] ADR_IEN     = 12'h304;
   localparam logic [11:0] ADR_TVEC    = 12'h305;
   localparam logic [11:0] ADR_SCRATCH = 12'h340;
   localparam logic [11:0] ADR_EPC     = 12'h341;
   localparam logic [11:0] ADR_CAUSE   = 12'h342;
   localparam logic [11:0] ADR_TVAL    = 12'h343;
   localparam logic [11:0] ADR_IPEND   = 12'h344;
   localparam logic [11:0] ADR_VENDOR  = 12'hF11;
   localparam logic [11:0] ADR_ARCH    = 12'hF12;
   localparam logic [11:0] ADR_IMPL    = 12'hF13;
   localparam logic [11:0] ADR_HART    = 12'hF14;
   localparam logic [11:0] ADR_CYC_LO  = 12'hB00;
   localparam logic [11:0] ADR_RET_LO  = 12'hB02;
   localparam logic [11:0] ADR_CYC_HI  = 12'hB80;
   localparam logic [11:0] ADR_RET_HI  = 12'hB82;

   localparam int BIT_IE   = 3;
   localparam int BIT_PIE  = 7;
   localparam int CAUSE_ILLEGAL = 2;
endpackage

// File: rtl/mcsr_modify.sv
module mcsr_modify
   import mcsr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  csr_op_e            kind,
   input  logic               imm,
   input  logic [ZIMM_W-1:0]  zimm,
   input  logic [XLEN-1:0]    rs1_val,
   input  logic               rs1_zero,
   input  logic [XLEN-1:0]    old_val,
   output logic [XLEN-1:0]    new_val,
   output logic               wr_try
);
   logic [XLEN-1:0] src;
   logic            src_zero;

   always_comb begin
      src      = imm ? XLEN'(zimm) : rs1_val;
      src_zero = imm ? (zimm == '0) : rs1_zero;
      unique case (kind)
         OP_WRITE: new_val = src;
         OP_SET:   new_val = old_val | src;
         OP_CLEAR: new_val = old_val & ~src;
         default:  new_val = old_val;
      endcase
      wr_try = (kind == OP_WRITE) ||
               (((kind == OP_SET) || (kind == OP_CLEAR)) && !src_zero);
   end
endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
   parameter int XLEN  = 32,
   parameter int CNT_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] lo,
   output logic [XLEN-1:0] hi
);
   localparam int HI_W = CNT_W - XLEN;

   if (CNT_W < XLEN || CNT_W > 2*XLEN) begin : g_bad_width
      $error("mcsr_counter: CNT_W must lie between XLEN and 2*XLEN");
   end

   if (HI_W > 0) begin : g_split
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (wr_lo) cnt_q[XLEN-1:0] <= wdata;
         else if (wr_hi) cnt_q[CNT_W-1:XLEN] <= wdata[HI_W-1:0];
         else if (inc)   cnt_q <= cnt_q + 1'b1;
      end
      assign lo = cnt_q[XLEN-1:0];
      assign hi = XLEN'(cnt_q[CNT_W-1:XLEN]);

      AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (inc && !wr_lo && !wr_hi) |=> {hi, lo} == $past({hi, lo}) + 1'b1); // R10
      AST_CNT_WR_HI: assert property (@(posedge clk) disable iff (!rst_n)
         wr_hi |=> (hi == XLEN'($past(wdata[HI_W-1:0]))) && $stable(lo)); // R12
   end else begin : g_single
      logic [XLEN-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (wr_lo) cnt_q <= wdata;
         else if (inc)   cnt_q <= cnt_q + 1'b1;
      end
      assign lo = cnt_q;
      assign hi = '0;
   end

   AST_CNT_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> lo == $past(wdata)); // R12
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
   import mcsr_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          CAUSE_W   = 5,
   parameter int          CNT_W     = 64,
   parameter logic [31:0] ISA_VAL   = 32'h4000_1100,
   parameter logic [31:0] VENDOR_ID = 32'h0,
   parameter logic [31:0] ARCH_ID   = 32'h0,
   parameter logic [31:0] IMPL_ID   = 32'h1,
   parameter logic [31:0] HART_ID   = 32'h0,
   parameter logic [31:0] IEN_MASK  = 32'h0000_0888
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic               op_valid,
   input  logic [1:0]         op_kind,
   input  logic               op_imm,
   input  logic [11:0]        csr_addr,
   input  logic [XLEN-1:0]    rs1_val,
   input  logic [ZIMM_W-1:0]  zimm,
   input  logic               rd_zero,
   input  logic               rs1_zero,
   input  logic               trap_req,
   input  logic [CAUSE_W-1:0] trap_cause,
   input  logic               mret_req,
   input  logic               retire,
   output logic [XLEN-1:0]    rdata,
   output logic               illegal,
   output logic               redirect,
   output logic [XLEN-1:0]    redirect_pc
);
   localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);
   localparam logic [XLEN-1:0] PP_MACHINE = XLEN'(32'h0000_1800);
   localparam int              N_CNT      = 2;

   if (XLEN != 32) begin : g_bad_xlen
      $error("mcsr_trap_unit: only a 32-bit register file is supported");
   end
   if (CAUSE_W < 2 || CAUSE_W > XLEN) begin : g_bad_cause
      $error("mcsr_trap_unit: CAUSE_W out of range");
   end

   csr_op_e         kind;
   logic            st_ie_q, st_pie_q;
   logic [XLEN-1:0] ien_q, tvec_q, scratch_q, epc_q, cause_q, tval_q;
   logic [XLEN-1:0] old_val, new_val, trap_code;
   logic [XLEN-1:0] cnt_lo [N_CNT];
   logic [XLEN-1:0] cnt_hi [N_CNT];
   logic            hit, wr_try, acc_bad, do_wr, take_trap, do_mret;

   assign kind = csr_op_e'(op_kind);

   always_comb begin
      hit = 1'b1;
      unique case (csr_addr)
         ADR_STATUS:  old_val = PP_MACHINE | (XLEN'(st_pie_q) << BIT_PIE)
                                           | (XLEN'(st_ie_q) << BIT_IE);
         ADR_ISA:     old_val = ISA_VAL;
         ADR_IEN:     old_val = ien_q;
         ADR_TVEC:    old_val = tvec_q;
         ADR_SCRATCH: old_val = scratch_q;
         ADR_EPC:     old_val = epc_q;
         ADR_CAUSE:   old_val = cause_q;
         ADR_TVAL:    old_val = tval_q;
         ADR_IPEND:   old_val = '0;
         ADR_VENDOR:  old_val = VENDOR_ID;
         ADR_ARCH:    old_val = ARCH_ID;
         ADR_IMPL:    old_val = IMPL_ID;
         ADR_HART:    old_val = HART_ID;
         ADR_CYC_LO:  old_val = cnt_lo[0];
         ADR_CYC_HI:  old_val = cnt_hi[0];
         ADR_RET_LO:  old_val = cnt_lo[1];
         ADR_RET_HI:  old_val = cnt_hi[1];
         default: begin
            old_val = '0;
            hit     = 1'b0;
         end
      endcase
   end

   mcsr_modify #(.XLEN(XLEN)) u_modify (
      .kind     (kind),
      .imm      (op_imm),
      .zimm     (zimm),
      .rs1_val  (rs1_val),
      .rs1_zero (rs1_zero),
      .old_val  (old_val),
      .new_val  (new_val),
      .wr_try   (wr_try)
   );

   assign acc_bad   = op_valid && (!hit || (wr_try && csr_addr[11:10] == 2'b11));
   assign take_trap = trap_req || acc_bad;
   assign do_wr     = op_valid && wr_try && !take_trap;
   assign do_mret   = mret_req && !take_trap;
   assign trap_code = trap_req ? XLEN'(trap_cause) : XLEN'(CAUSE_ILLEGAL);

   assign rdata       = (op_valid && !acc_bad && !(kind == OP_WRITE && rd_zero)) ? old_val : '0;
   assign illegal     = acc_bad;
   assign redirect    = take_trap || do_mret;
   assign redirect_pc = take_trap ? tvec_q : epc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_ie_q   <= 1'b0;
         st_pie_q  <= 1'b0;
         ien_q     <= '0;
         tvec_q    <= '0;
         scratch_q <= '0;
         epc_q     <= '0;
         cause_q   <= '0;
         tval_q    <= '0;
      end else if (take_trap) begin
         st_pie_q <= st_ie_q;
         st_ie_q  <= 1'b0;
         epc_q    <= cur_pc & ALIGN_MASK;
         cause_q  <= trap_code;
         tval_q   <= '0;
      end else if (do_mret) begin
         st_ie_q  <= st_pie_q;
         st_pie_q <= 1'b1;
      end else if (do_wr) begin
         unique case (csr_addr)
            ADR_STATUS: begin
               st_ie_q  <= new_val[BIT_IE];
               st_pie_q <= new_val[BIT_PIE];
            end
            ADR_IEN:     ien_q     <= new_val & IEN_MASK;
            ADR_TVEC:    tvec_q    <= new_val & ALIGN_MASK;
            ADR_SCRATCH: scratch_q <= new_val;
            ADR_EPC:     epc_q     <= new_val & ALIGN_MASK;
            ADR_CAUSE:   cause_q   <= new_val;
            ADR_TVAL:    tval_q    <= new_val;
            default: ;
         endcase
      end
   end

   for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
      localparam logic [11:0] A_LO = (gi == 0) ? ADR_CYC_LO : ADR_RET_LO;
      localparam logic [11:0] A_HI = (gi == 0) ? ADR_CYC_HI : ADR_RET_HI;
      mcsr_counter #(.XLEN(XLEN), .CNT_W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   ((gi == 0) ? 1'b1 : retire),
         .wr_lo (do_wr && csr_addr == A_LO),
         .wr_hi (do_wr && csr_addr == A_HI),
         .wdata (new_val),
         .lo    (cnt_lo[gi]),
         .hi    (cnt_hi[gi])
      );
   end

   AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_req, op_valid, mret_req})); // R7
   AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> redirect && redirect_pc == tvec_q); // R7
   AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> cause_q == XLEN'($past(trap_cause))); // R7
   AST_TRAP_IE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect && redirect_pc == tvec_q && !mret_req |=> !st_ie_q && st_pie_q == $past(st_ie_q)); // R8
   AST_MRET_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_req && !trap_req && !op_valid) |=> st_pie_q && st_ie_q == $past(st_pie_q)); // R9
   AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && kind == OP_WRITE && csr_addr[11:10] == 2'b11) |-> illegal && redirect); // R6
   AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !trap_req) |=> cause_q == XLEN'(CAUSE_ILLEGAL) && tval_q == '0); // R6
   AST_RET_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (mret_req && !trap_req && !op_valid) |-> redirect && redirect_pc[1:0] == 2'b00); // R13
endmodule

// File: tb/mcsr_trap_unit_bench.sv
module mcsr_trap_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cur_pc = '0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = '0;
   logic        op_imm = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [31:0] rs1_val = '0;
   logic [4:0]  zimm = '0;
   logic        rd_zero = 1'b0;
   logic        rs1_zero = 1'b0;
   logic        trap_req = 1'b0;
   logic [4:0]  trap_cause = '0;
   logic        mret_req = 1'b0;
   logic        retire = 1'b0;
   logic [31:0] rdata, redirect_pc;
   logic        illegal, redirect;

   mcsr_trap_unit u_mcsr_trap_unit (
      .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .op_valid(op_valid),
      .op_kind(op_kind), .op_imm(op_imm), .csr_addr(csr_addr),
      .rs1_val(rs1_val), .zimm(zimm), .rd_zero(rd_zero), .rs1_zero(rs1_zero),
      .trap_req(trap_req), .trap_cause(trap_cause), .mret_req(mret_req),
      .retire(retire), .rdata(rdata), .illegal(illegal),
      .redirect(redirect), .redirect_pc(redirect_pc)
   );

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // bench copy of the writable state
   bit          m_ie, m_pie;
   logic [31:0] m_ien, m_tvec, m_scr, m_epc, m_cause, m_tval;
   logic [31:0] g_rdata, g_rpc;
   logic        g_ill, g_redir;

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [11:0] a);
      case (a)
         12'h300: return 32'h1800 | (32'(m_pie) << 7) | (32'(m_ie) << 3);
         12'h304: return m_ien;
         12'h305: return m_tvec;
         12'h340: return m_scr;
         12'h341: return m_epc;
         12'h342: return m_cause;
         12'h343: return m_tval;
         default: return 32'h0;
      endcase
   endfunction

   function automatic void m_write(logic [11:0] a, logic [31:0] v);
      case (a)
         12'h300: begin m_ie = v[3]; m_pie = v[7]; end
         12'h304: m_ien = v & 32'h888;
         12'h305: m_tvec = v & ~32'h3;
         12'h340: m_scr = v;
         12'h341: m_epc = v & ~32'h3;
         12'h342: m_cause = v;
         12'h343: m_tval = v;
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] f_mod(logic [1:0] k, logic [31:0] o, logic [31:0] s);
      case (k)
         2'b01: return s;
         2'b10: return o | s;
         2'b11: return o & ~s;
         default: return o;
      endcase
   endfunction

   function automatic void m_trap(logic [31:0] pc, logic [31:0] c);
      m_pie = m_ie; m_ie = 1'b0;
      m_epc = pc & ~32'h3; m_cause = c; m_tval = '0;
   endfunction

   task automatic csr(logic [1:0] k, logic im, logic [11:0] a, logic [31:0] s,
                      logic [4:0] z, logic rd0, logic rs0, logic ret);
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_imm = im; csr_addr = a;
      rs1_val = s; zimm = z; rd_zero = rd0; rs1_zero = rs0; retire = ret;
      #5;
      g_rdata = rdata; g_ill = illegal; g_redir = redirect; g_rpc = redirect_pc;
      @(posedge clk); #1;
      op_valid = 1'b0; retire = 1'b0;
   endtask

   task automatic rd(logic [11:0] a);
      csr(2'b10, 1'b0, a, 32'h0, 5'd0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic trap(logic [4:0] c, logic [31:0] pc);
      @(negedge clk);
      trap_req = 1'b1; trap_cause = c; cur_pc = pc;
      #5;
      chk("R7 trap redirect", 32'(redirect), 32'h1);
      chk("R7 trap target", redirect_pc, m_tvec);
      @(posedge clk); #1;
      trap_req = 1'b0;
      m_trap(pc, 32'(c));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_ie = 0; m_pie = 0; m_ien = 0; m_tvec = 0; m_scr = 0;
      m_epc = 0; m_cause = 0; m_tval = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R5 reset and constant values
      rd(12'h300); chk("R5 status reset", g_rdata, 32'h1800);
      rd(12'h301); chk("R5 isa", g_rdata, 32'h4000_1100);
      rd(12'hF11); chk("R5 vendor", g_rdata, 32'h0);
      rd(12'hF12); chk("R5 arch", g_rdata, 32'h0);
      rd(12'hF13); chk("R5 impl", g_rdata, 32'h1);
      rd(12'hF14); chk("R5 hart", g_rdata, 32'h0);
      chk("R3 zero-source set on read-only is legal", 32'(g_ill), 32'h0);
      csr(2'b11, 1'b1, 12'hF13, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b0, 1'b0);
      chk("R3 zimm=0 clear on read-only legal", 32'(g_ill), 32'h0);
      chk("R3 zimm=0 clear returns value", g_rdata, 32'h1);

      // R1 trap vector setup
      csr(2'b01, 1'b0, 12'h305, 32'h8000_0103, 5'd0, 1'b0, 1'b0, 1'b0);
      m_write(12'h305, 32'h8000_0103);
      rd(12'h305); chk("R13 tvec low bits", g_rdata, 32'h8000_0100);

      // R2 immediate source ignores rs1_val
      csr(2'b01, 1'b1, 12'h340, 32'hDEAD_BEEF, 5'h15, 1'b0, 1'b0, 1'b0);
      m_write(12'h340, 32'h15);
      rd(12'h340); chk("R2 zimm zero-extended", g_rdata, 32'h15);

      // R4 write with rd=x0
      csr(2'b01, 1'b0, 12'h340, 32'hCAFE_0001, 5'd0, 1'b1, 1'b0, 1'b0);
      chk("R4 rd zero gives zero rdata", g_rdata, 32'h0);
      m_write(12'h340, 32'hCAFE_0001);
      rd(12'h340); chk("R4 write still happens", g_rdata, 32'hCAFE_0001);

      // R13 field masks
      csr(2'b01, 1'b0, 12'h341, 32'h0000_1003, 5'd0, 1'b0, 1'b0, 1'b0);
      m_write(12'h341, 32'h1003);
      rd(12'h341); chk("R13 epc low bits", g_rdata, 32'h1000);
      csr(2'b01, 1'b0, 12'h304, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b0, 1'b0);
      m_write(12'h304, 32'hFFFF_FFFF);
      rd(12'h304); chk("R13 ien mask", g_rdata, 32'h888);
      csr(2'b01, 1'b0, 12'h344, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b0, 1'b0);
      chk("R13 pending write legal", 32'(g_ill), 32'h0);
      rd(12'h344); chk("R13 pending reads zero", g_rdata, 32'h0);

      // R8 trap entry with enable set
      csr(2'b10, 1'b0, 12'h300, 32'h8, 5'd0, 1'b0, 1'b0, 1'b0);
      m_write(12'h300, 32'h1808);
      trap(5'd11, 32'h0000_2006);
      rd(12'h341); chk("R7 epc saved", g_rdata, 32'h2004);
      rd(12'h342); chk("R7 cause saved", g_rdata, 32'd11);
      rd(12'h300); chk("R8 status after trap", g_rdata, 32'h1880);

      // R9 return
      @(negedge clk); mret_req = 1'b1; #5;
      chk("R9 mret redirect", 32'(redirect), 32'h1);
      chk("R9 mret target", redirect_pc, 32'h2004);
      @(posedge clk); #1 mret_req = 1'b0;
      m_ie = m_pie; m_pie = 1'b1;
      rd(12'h300); chk("R9 status after mret", g_rdata, 32'h1888);

      // R6 illegal accesses
      cur_pc = 32'h0000_3008;
      csr(2'b01, 1'b0, 12'hF12, 32'h5, 5'd0, 1'b0, 1'b0, 1'b0);
      chk("R6 ro write illegal", 32'(g_ill), 32'h1);
      chk("R6 ro write redirect", 32'(g_redir), 32'h1);
      chk("R6 ro write target", g_rpc, m_tvec);
      m_trap(32'h3008, 32'd2);
      rd(12'h342); chk("R6 cause illegal", g_rdata, 32'd2);
      rd(12'h343); chk("R6 tval zero", g_rdata, 32'h0);
      rd(12'h341); chk("R6 epc", g_rdata, 32'h3008);
      rd(12'hF12); chk("R6 ro unchanged", g_rdata, 32'h0);
      rd(12'h7C0); chk("R6 unimplemented illegal", 32'(g_ill), 32'h1);
      m_trap(32'h3008, 32'd2);
      rd(12'h300); chk("R8 status after illegal trap", g_rdata, m_read(12'h300));

      // R10 cycle counter split and carry
      csr(2'b01, 1'b0, 12'hB80, 32'h5, 5'd0, 1'b0, 1'b0, 1'b0);
      csr(2'b01, 1'b0, 12'hB00, 32'hFFFF_FFFF, 5'd0, 1'b0, 1'b0, 1'b0);
      rd(12'hB80); chk("R12 cycle write replaces increment", g_rdata, 32'h5);
      rd(12'hB80); chk("R10 carry into high half", g_rdata, 32'h6);
      csr(2'b01, 1'b0, 12'hB00, 32'h100, 5'd0, 1'b0, 1'b0, 1'b0);
      rd(12'hB00); chk("R10 cycle low after write", g_rdata, 32'h100);
      rd(12'hB00); chk("R10 cycle increments", g_rdata, 32'h101);

      // R11 retire counter
      csr(2'b01, 1'b0, 12'hB02, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0);
      @(negedge clk); retire = 1'b1;
      repeat (3) @(posedge clk);
      #1 retire = 1'b0;
      rd(12'hB02); chk("R11 retire count", g_rdata, 32'h3);
      csr(2'b01, 1'b0, 12'hB02, 32'd100, 5'd0, 1'b0, 1'b0, 1'b1);
      rd(12'hB02); chk("R12 write beats retire", g_rdata, 32'd100);
      rd(12'hB82); chk("R11 retire high", g_rdata, 32'h0);

      // R1 R2 constrained random on fully writable registers
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 200; i++) begin
         logic [11:0] a;
         logic [1:0]  k;
         logic        im, rd0, rs0, wr;
         logic [4:0]  z;
         logic [31:0] s, src, expo;
         case ($urandom_range(0, 5))
            0: a = 12'h340; 1: a = 12'h305; 2: a = 12'h304;
            3: a = 12'h341; 4: a = 12'h342; default: a = 12'h343;
         endcase
         k   = 2'($urandom_range(1, 3));
         im  = 1'($urandom_range(0, 1));
         z   = 5'($urandom_range(0, 31));
         rs0 = ($urandom_range(0, 7) == 0);
         s   = rs0 ? 32'h0 : $urandom();
         rd0 = ($urandom_range(0, 7) == 0);
         src = im ? 32'(z) : s;
         wr  = (k == 2'b01) || (src != 0);
         expo = (k == 2'b01 && rd0) ? 32'h0 : m_read(a);
         csr(k, im, a, s, z, rd0, rs0, 1'b0);
         chk(im ? "R2 random old value" : "R1 random old value", g_rdata, expo);
         chk("R1 random legal", 32'(g_ill), 32'h0);
         if (wr) m_write(a, f_mod(k, m_read(a), src));
      end
      for (int j = 0; j < 6; j++) begin
         logic [11:0] a;
         a = (j == 0) ? 12'h340 : (j == 1) ? 12'h305 : (j == 2) ? 12'h304 :
             (j == 3) ? 12'h341 : (j == 4) ? 12'h342 : 12'h343;
         rd(a); chk("R1 final register", g_rdata, m_read(a));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule